// File: doc/BRIEF.md
# SPI Register-Access Slave

This block lets an external host read and write a byte-addressed timekeeping register file over a four-wire serial link. The host lowers chip select and sends a command byte, then a start address byte. After that it streams data. A write command delivers bytes that land in consecutive registers. A read command makes the slave return the contents of consecutive registers for as long as chip select stays low.

The serial pins are sampled by the system clock through synchroniser stages, so the whole block runs in one clock domain. The serial clock must therefore be several system clocks slower than the system clock. The register file sits outside the block and presents read data combinationally for the address the block drives.

Command codes used for memory, identity, watchdog and clear functions belong to the same command space. This block recognises none of them as register accesses. It treats every code other than the two register commands as a transaction to skip, and stays silent until chip select rises.

Top module: `spi_regacc_slave`

## Requirements
- R1: After reset, `reg_we` and `spi_miso_oe` are 0.
- R2: The link uses clock idle low, 8-bit words and MSB first. The slave samples MOSI on the rising serial clock edge and changes MISO only after a falling edge.
- R3: Command byte 0x13 followed by an address byte starts a read. Each following byte time returns, MSB first on `spi_miso`, the register at the current address, with `spi_miso_oe` high.
- R4: Command byte 0x12 followed by an address byte starts a write. Each complete data byte raises `reg_we` for exactly one system clock, with that byte on `reg_wdata` and the current address on `reg_addr`.
- R5: The address starts at the given address byte and increases by one after every data byte of a burst, in both directions. It wraps from 0xFF to 0x00.
- R6: Any other command byte (for example 0x01 to 0x06, 0x14, 0x32, 0x33, 0x44 or 0x54) causes no `reg_we` pulse and keeps `spi_miso_oe` low until chip select rises.
- R7: Raising chip select at any point ends the transaction and clears the bit count. A partially received byte is never written, and the next transaction starts with a fresh command byte.
- R8: `spi_miso_oe` is low whenever chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sck | input | 1 | Serial clock from host |
| spi_csn | input | 1 | Active-low chip select |
| spi_mosi | input | 1 | Serial data from host |
| spi_miso | output | 1 | Serial data to host |
| spi_miso_oe | output | 1 | Output enable for the MISO pad driver |
| reg_addr | output | ADDR_W | Register file address |
| reg_wdata | output | 8 | Register write data |
| reg_we | output | 1 | One-clock register write strobe |
| reg_rdata | input | 8 | Register read data for `reg_addr` |

## Verification
The assertions take for granted that each serial clock level lasts several system clocks. That way every edge is seen once after synchronisation, and a full byte never completes within two system clocks of the previous one. They also assume chip select changes only while the serial clock is low. The bench master keeps each serial clock half period at ten system clocks and moves chip select only with the clock idle low. It changes its inputs away from system clock edges, so these assumptions always hold.

// File: rtl/spi_regacc_pkg.sv
package spi_regacc_pkg;
   localparam int BYTE_W = 8;
   localparam logic [BYTE_W-1:0] CMD_REG_WRITE = 8'h12;
   localparam logic [BYTE_W-1:0] CMD_REG_READ  = 8'h13;

   typedef enum logic [2:0] {
      PH_COMMAND,
      PH_ADDRESS,
      PH_WR_DATA,
      PH_RD_DATA,
      PH_SKIP
   } phase_e;
endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
   parameter int W = 3,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_stages
      $error("spi_pin_sync needs at least two stages");
   end

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [W-1:0] r;
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) r <= RST_VAL;
            else        r <= g_stage[g-1].r;
         end
      end
   end

   assign q = g_stage[STAGES-1].r;
endmodule

// File: rtl/spi_rx_shifter.sv
module spi_rx_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         sck_s,
   input  logic         csn_s,
   input  logic         mosi_s,
   output logic         sck_fall,
   output logic         at_boundary,
   output logic         rx_valid,
   output logic [W-1:0] rx_byte
);
   localparam int CW = (W > 1) ? $clog2(W) : 1;
   localparam logic [CW-1:0] LAST = CW'(W - 1);

   logic          sck_q;
   logic          sck_rise;
   logic [CW-1:0] cnt;
   logic [W-1:0]  shreg;

   assign sck_rise    = sck_s & ~sck_q & ~csn_s;
   assign sck_fall    = ~sck_s & sck_q & ~csn_s;
   assign at_boundary = (cnt == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sck_q <= 1'b0;
      else        sck_q <= sck_s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         shreg    <= '0;
         rx_valid <= 1'b0;
         rx_byte  <= '0;
      end else if (csn_s) begin
         cnt      <= '0;
         shreg    <= '0;
         rx_valid <= 1'b0;
      end else begin
         rx_valid <= 1'b0;
         if (sck_rise) begin
            shreg <= {shreg[W-2:0], mosi_s};
            if (cnt == LAST) begin
               cnt      <= '0;
               rx_valid <= 1'b1;
               rx_byte  <= {shreg[W-2:0], mosi_s};
            end else begin
               cnt <= cnt + 1'b1;
            end
         end
      end
   end

   // R7: deselect clears the bit count and suppresses any byte
   p_cnt_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
      csn_s |=> (cnt == '0) && !rx_valid);
endmodule

// File: rtl/spi_cmd_ctrl.sv
module spi_cmd_ctrl
   import spi_regacc_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csn_s,
   input  logic              rx_valid,
   input  logic [BYTE_W-1:0] rx_byte,
   output phase_e            phase,
   output logic [ADDR_W-1:0] reg_addr,
   output logic              reg_we,
   output logic [BYTE_W-1:0] reg_wdata
);
   logic wr_mode;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_COMMAND;
         wr_mode   <= 1'b0;
         reg_addr  <= '0;
         reg_we    <= 1'b0;
         reg_wdata <= '0;
      end else begin
         reg_we <= 1'b0;
         if (reg_we) reg_addr <= reg_addr + 1'b1;
         if (csn_s) begin
            phase <= PH_COMMAND;
         end else if (rx_valid) begin
            unique case (phase)
               PH_COMMAND: begin
                  if (rx_byte == CMD_REG_WRITE) begin
                     phase   <= PH_ADDRESS;
                     wr_mode <= 1'b1;
                  end else if (rx_byte == CMD_REG_READ) begin
                     phase   <= PH_ADDRESS;
                     wr_mode <= 1'b0;
                  end else begin
                     phase <= PH_SKIP;
                  end
               end
               PH_ADDRESS: begin
                  reg_addr <= rx_byte[ADDR_W-1:0];
                  phase    <= wr_mode ? PH_WR_DATA : PH_RD_DATA;
               end
               PH_WR_DATA: begin
                  reg_we    <= 1'b1;
                  reg_wdata <= rx_byte;
               end
               PH_RD_DATA: reg_addr <= reg_addr + 1'b1;
               default:    phase <= PH_SKIP;
            endcase
         end
      end
   end

   // R4: write strobe lasts one system clock
   p_we_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> !reg_we);
   // R5: every write advances the address by one (wrapping)
   p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      reg_we |=> reg_addr == $past(reg_addr) + 1'b1);
   // R6: a skipped command never writes
   p_skip_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SKIP) |=> !reg_we);
endmodule

// File: rtl/spi_tx_shifter.sv
module spi_tx_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         csn_s,
   input  logic         sck_fall,
   input  logic         at_boundary,
   input  logic         rd_phase,
   input  logic [W-1:0] rdata,
   output logic         miso,
   output logic         miso_oe
);
   logic [W-1:0] txreg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         txreg <= '0;
      end else if (csn_s) begin
         txreg <= '0;
      end else if (sck_fall && rd_phase) begin
         if (at_boundary) txreg <= rdata;
         else             txreg <= {txreg[W-2:0], 1'b0};
      end
   end

   assign miso    = txreg[W-1];
   assign miso_oe = rd_phase & ~csn_s;

   // R2: MISO only moves after a falling serial clock edge
   p_miso_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!sck_fall && !csn_s) |=> ($stable(miso) || csn_s));
endmodule

// File: rtl/spi_regacc_slave.sv
module spi_regacc_slave
   import spi_regacc_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_sck,
   input  logic              spi_csn,
   input  logic              spi_mosi,
   output logic              spi_miso,
   output logic              spi_miso_oe,
   output logic [ADDR_W-1:0] reg_addr,
   output logic [BYTE_W-1:0] reg_wdata,
   output logic              reg_we,
   input  logic [BYTE_W-1:0] reg_rdata
);
   if (ADDR_W < 1 || ADDR_W > BYTE_W) begin : g_bad_addr_w
      $error("ADDR_W must lie between 1 and 8");
   end

   logic              sck_s, csn_s, mosi_s;
   logic              sck_fall, at_boundary, rx_valid;
   logic [BYTE_W-1:0] rx_byte;
   phase_e            phase;

   spi_pin_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) i_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({spi_sck, spi_csn, spi_mosi}),
      .q     ({sck_s, csn_s, mosi_s})
   );

   spi_rx_shifter #(.W(BYTE_W)) i_rx (
      .clk         (clk),
      .rst_n       (rst_n),
      .sck_s       (sck_s),
      .csn_s       (csn_s),
      .mosi_s      (mosi_s),
      .sck_fall    (sck_fall),
      .at_boundary (at_boundary),
      .rx_valid    (rx_valid),
      .rx_byte     (rx_byte)
   );

   spi_cmd_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .csn_s     (csn_s),
      .rx_valid  (rx_valid),
      .rx_byte   (rx_byte),
      .phase     (phase),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata)
   );

   spi_tx_shifter #(.W(BYTE_W)) i_tx (
      .clk         (clk),
      .rst_n       (rst_n),
      .csn_s       (csn_s),
      .sck_fall    (sck_fall),
      .at_boundary (at_boundary),
      .rd_phase    (phase == PH_RD_DATA),
      .rdata       (reg_rdata),
      .miso        (spi_miso),
      .miso_oe     (spi_miso_oe)
   );

   // R6: skipped commands keep the MISO driver off
   p_skip_no_oe_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SKIP) |-> !spi_miso_oe);
endmodule

// File: tb/test_spi_regacc_slave.sv
module test_spi_regacc_slave;
   localparam time CLK_PERIOD = 10ns;
   localparam time HALF_SCK   = 100ns;
   localparam int  NVEC       = 14;
   // {command, start address, byte count, data seed}
   localparam logic [31:0] VEC [NVEC] = '{
      32'h12_10_01_3C, 32'h12_20_04_50, 32'h12_FE_03_A0, 32'h13_20_04_00,
      32'h13_FE_03_00, 32'h03_20_03_77, 32'h02_30_02_88, 32'h06_20_02_11,
      32'h14_21_02_22, 32'h32_22_01_33, 32'h44_23_01_44, 32'h54_24_01_55,
      32'h05_10_02_66, 32'h13_10_01_00
   };

   logic       clk = 0, rst_n = 0;
   logic       sck = 0, csn = 1, mosi = 0;
   logic       miso, miso_oe, reg_we;
   logic [7:0] reg_addr, reg_wdata, reg_rdata;
   logic [7:0] regmem [256];
   logic [7:0] expmem [256];
   int         we_cnt = 0, checks = 0, fails = 0;
   logic       oe_seen = 0, oe_clr = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_regacc_slave i_spi_regacc_slave (
      .clk(clk), .rst_n(rst_n), .spi_sck(sck), .spi_csn(csn), .spi_mosi(mosi),
      .spi_miso(miso), .spi_miso_oe(miso_oe), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_we(reg_we), .reg_rdata(reg_rdata));

   // register file stand-in
   assign reg_rdata = regmem[reg_addr];
   always @(posedge clk) begin
      if (reg_we) begin
         regmem[reg_addr] <= reg_wdata;
         we_cnt <= we_cnt + 1;
      end
      if (oe_clr) oe_seen <= 1'b0;
      else if (miso_oe) oe_seen <= 1'b1;
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic xbyte(input logic [7:0] t, input int nbits, output logic [7:0] r);
      r = 8'h00;
      for (int i = 7; i > 7 - nbits; i--) begin
         mosi = t[i];
         #(HALF_SCK);
         r[i] = miso;
         sck = 1;
         #(HALF_SCK);
         sck = 0;
      end
   endtask

   task automatic select();
      oe_clr = 1; #(CLK_PERIOD); oe_clr = 0;
      csn = 0;
      #(HALF_SCK);
   endtask

   task automatic deselect();
      #(HALF_SCK);
      csn = 1;
      #(4*HALF_SCK);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [7:0] rb;
      for (int i = 0; i < 256; i++) begin
         regmem[i] = 8'(i * 7 + 3);
         expmem[i] = 8'(i * 7 + 3);
      end
      #3ns;
      #(CLK_PERIOD * 3);
      // R1: reset state
      check("R1 oe", {31'd0, miso_oe}, 32'd0);
      check("R1 we", {31'd0, reg_we}, 32'd0);
      rst_n = 1;
      #(CLK_PERIOD * 5);

      for (int v = 0; v < NVEC; v++) begin
         logic [7:0] op, ad, len, seed;
         int we0;
         {op, ad, len, seed} = VEC[v];
         we0 = we_cnt;
         select();
         xbyte(op, 8, rb);
         xbyte(ad, 8, rb);
         for (int k = 0; k < int'(len); k++) begin
            logic [7:0] a;
            a = ad + 8'(k);
            xbyte((op == 8'h13) ? 8'hFF : seed + 8'(k), 8, rb);
            if (op == 8'h13) begin
               // R2 R3 R5: MSB-first read of consecutive registers
               check("R3 read data", rb, expmem[a]);
            end
         end
         deselect();
         if (op == 8'h12) begin
            check("R4 write count", we_cnt - we0, len);
            for (int k = 0; k < int'(len); k++) begin
               logic [7:0] a;
               a = ad + 8'(k);
               expmem[a] = seed + 8'(k);
               check("R5 written register", regmem[a], expmem[a]);
            end
         end else if (op == 8'h13) begin
            check("R3 oe during read", {31'd0, oe_seen}, 32'd1);
         end else begin
            check("R6 no write", we_cnt - we0, 32'd0);
            check("R6 oe quiet", {31'd0, oe_seen}, 32'd0);
         end
         check("R8 oe after deselect", {31'd0, miso_oe}, 32'd0);
      end

      // R7: partial byte after a full one is discarded
      begin
         int we0;
         we0 = we_cnt;
         select();
         xbyte(8'h12, 8, rb);
         xbyte(8'h40, 8, rb);
         xbyte(8'h5A, 8, rb);
         xbyte(8'hC3, 5, rb);
         deselect();
         expmem[8'h40] = 8'h5A;
         check("R7 one write only", we_cnt - we0, 32'd1);
         check("R7 full byte kept", regmem[8'h40], 8'h5A);
         check("R7 partial dropped", regmem[8'h41], expmem[8'h41]);
      end
      // R7: abort inside command byte, then fresh read decodes
      select();
      xbyte(8'h13, 4, rb);
      deselect();
      select();
      xbyte(8'h13, 8, rb);
      xbyte(8'h40, 8, rb);
      xbyte(8'hFF, 8, rb);
      check("R7 fresh read", rb, 8'h5A);
      xbyte(8'hFF, 8, rb);
      check("R5 read increment", rb, expmem[8'h41]);
      deselect();
      check("R8 oe after abort", {31'd0, miso_oe}, 32'd0);

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule